// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds or subtracts two operands, each held as a sign, an unsigned exponent and an explicit mantissa, the value being the mantissa scaled by two raised to the exponent. The work is cut into four segments, each ending in a register. The first compares the exponents. The second shifts the mantissa that has the smaller exponent into line. The third combines the aligned magnitudes. The fourth renormalizes the result. A new operand pair can be presented on every clock. Each result leaves the block a fixed four cycles later, with a valid flag that travels beside the data.

The default format has an 8-bit exponent and a 16-bit mantissa. A normalized mantissa has its most significant bit set. Inputs need not be normalized. Every non-zero output is normalized. The block does no rounding and has no special encodings: a bit shifted out during alignment is dropped, and exponent range limits are handled by saturation or by flushing to zero. A host pipeline feeds operand pairs with `in_valid` and collects results on `out_valid`.

Top module: `fpa_pipe_adder`

## Requirements
- R1: A pair presented with `in_valid` high at clock edge k yields `out_valid` high right after edge k+4. `out_valid` is low in every cycle that has no such pair, and back-to-back pairs give back-to-back results.
- R2: With `in_sub` = 1 the block computes a − b by inverting the sign of b. With `in_sub` = 0 it computes a + b.
- R3: The operand with the smaller exponent has its mantissa shifted right by the exponent difference, and the shifted-out bits are dropped. The larger exponent is carried forward. When the exponents are equal, no shift takes place and a counts as the larger operand.
- R4: An exponent difference of at least the mantissa width (16) turns the shifted mantissa into zero.
- R5: Operands with like signs have their magnitudes added, and the result takes the common sign. Operands with unlike signs have the smaller aligned magnitude taken from the larger one, and the result takes the sign of the larger.
- R6: A carry out of the magnitude sum shifts the result right by one and adds one to the exponent. No result exponent exceeds the larger input exponent plus one.
- R7: A carry out at the largest exponent (all ones) saturates the result to the all-ones exponent and the all-ones mantissa.
- R8: Any other non-zero result is shifted left until bit 15 of the mantissa is 1, and the exponent is lowered by the shift count.
- R9: When the left shift count exceeds the carried exponent, the output is all zero.
- R10: A zero magnitude, including exact cancellation, produces sign 0, exponent 0 and mantissa 0.
- R11: While `rst_n` is low `out_valid` is low, and pairs accepted before a reset produce no result after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_sub | input | 1 | 1 selects a − b, 0 selects a + b |
| a_sign | input | 1 | Sign of a, 1 = negative |
| a_exp | input | EW (8) | Exponent of a |
| a_man | input | MW (16) | Mantissa of a |
| b_sign | input | 1 | Sign of b, 1 = negative |
| b_exp | input | EW (8) | Exponent of b |
| b_man | input | MW (16) | Mantissa of b |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EW (8) | Exponent of the result |
| out_man | output | MW (16) | Normalized mantissa of the result |

## Verification
In the last segment, two functions meet in the same cycle in two ways. A mantissa carry can arrive while the exponent already sits at its maximum, and there the increment must yield to saturation. A deep cancellation can call for a left shift larger than the exponent, and there the decrement must yield to the flush to zero. Directed operand pairs at exponent 255 and at small exponents provoke both cases. Both are also placed inside back-to-back streams, so that they share the pipeline with ordinary results. A behavioural reference in the bench computes each expected word from the requirements and compares it with the output in the exact cycle it falls due.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   // Default field widths of the operand format
   localparam int unsigned FPA_EW_DEF  = 8;
   localparam int unsigned FPA_MW_DEF  = 16;
   // Number of register-separated segments, equal to the latency in cycles
   localparam int unsigned FPA_STAGES  = 4;
endpackage

// File: rtl/fpa_seg_cmp.sv
// Segment 1: exponent comparison and operand ordering
module fpa_seg_cmp #(
   parameter int unsigned EW = 8,
   parameter int unsigned MW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sub,
   input  logic          a_sign,
   input  logic [EW-1:0] a_exp,
   input  logic [MW-1:0] a_man,
   input  logic          b_sign,
   input  logic [EW-1:0] b_exp,
   input  logic [MW-1:0] b_man,
   output logic          c_valid,
   output logic          c_big_sign,
   output logic [EW-1:0] c_big_exp,
   output logic [MW-1:0] c_big_man,
   output logic          c_sml_sign,
   output logic [MW-1:0] c_sml_man,
   output logic [EW-1:0] c_diff
);
   logic          b_eff_sign;
   logic          swap;
   logic [EW-1:0] diff_n;

   always_comb begin
      b_eff_sign = b_sign ^ in_sub;
      swap       = (b_exp > a_exp);
      diff_n     = swap ? (b_exp - a_exp) : (a_exp - b_exp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_valid    <= 1'b0;
         c_big_sign <= 1'b0;
         c_big_exp  <= '0;
         c_big_man  <= '0;
         c_sml_sign <= 1'b0;
         c_sml_man  <= '0;
         c_diff     <= '0;
      end else begin
         c_valid    <= in_valid;
         c_big_sign <= swap ? b_eff_sign : a_sign;
         c_big_exp  <= swap ? b_exp      : a_exp;
         c_big_man  <= swap ? b_man      : a_man;
         c_sml_sign <= swap ? a_sign     : b_eff_sign;
         c_sml_man  <= swap ? a_man      : b_man;
         c_diff     <= diff_n;
      end
   end
endmodule

// File: rtl/fpa_seg_align.sv
// Segment 2: right shift of the smaller-exponent mantissa
module fpa_seg_align #(
   parameter int unsigned EW = 8,
   parameter int unsigned MW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          c_valid,
   input  logic          c_big_sign,
   input  logic [EW-1:0] c_big_exp,
   input  logic [MW-1:0] c_big_man,
   input  logic          c_sml_sign,
   input  logic [MW-1:0] c_sml_man,
   input  logic [EW-1:0] c_diff,
   output logic          l_valid,
   output logic          l_big_sign,
   output logic          l_sml_sign,
   output logic [EW-1:0] l_exp,
   output logic [MW-1:0] l_big_man,
   output logic [MW-1:0] l_sml_man
);
   localparam longint unsigned DIFF_MAX = (64'd1 << EW) - 64'd1;

   logic [MW-1:0] aligned;

   generate
      if (DIFF_MAX >= MW) begin : g_clip
         // The difference can reach the width: clear the operand explicitly
         assign aligned = (c_diff >= EW'(MW)) ? '0 : (c_sml_man >> c_diff);
      end else begin : g_plain
         // The difference never reaches the width: a plain shift suffices
         assign aligned = c_sml_man >> c_diff;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_valid    <= 1'b0;
         l_big_sign <= 1'b0;
         l_sml_sign <= 1'b0;
         l_exp      <= '0;
         l_big_man  <= '0;
         l_sml_man  <= '0;
      end else begin
         l_valid    <= c_valid;
         l_big_sign <= c_big_sign;
         l_sml_sign <= c_sml_sign;
         l_exp      <= c_big_exp;
         l_big_man  <= c_big_man;
         l_sml_man  <= aligned;
      end
   end
endmodule

// File: rtl/fpa_seg_addsub.sv
// Segment 3: signed-magnitude combination of the aligned mantissas
module fpa_seg_addsub #(
   parameter int unsigned EW = 8,
   parameter int unsigned MW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          l_valid,
   input  logic          l_big_sign,
   input  logic          l_sml_sign,
   input  logic [EW-1:0] l_exp,
   input  logic [MW-1:0] l_big_man,
   input  logic [MW-1:0] l_sml_man,
   output logic          s_valid,
   output logic          s_sign,
   output logic [EW-1:0] s_exp,
   output logic [MW:0]   s_sum
);
   logic        same_sign;
   logic        big_ge;
   logic [MW:0] sum_n;
   logic        sign_n;

   always_comb begin
      same_sign = (l_big_sign == l_sml_sign);
      big_ge    = (l_big_man >= l_sml_man);
      if (same_sign) begin
         sum_n  = {1'b0, l_big_man} + {1'b0, l_sml_man};
         sign_n = l_big_sign;
      end else if (big_ge) begin
         sum_n  = {1'b0, l_big_man} - {1'b0, l_sml_man};
         sign_n = l_big_sign;
      end else begin
         sum_n  = {1'b0, l_sml_man} - {1'b0, l_big_man};
         sign_n = l_sml_sign;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_valid <= 1'b0;
         s_sign  <= 1'b0;
         s_exp   <= '0;
         s_sum   <= '0;
      end else begin
         s_valid <= l_valid;
         s_sign  <= sign_n;
         s_exp   <= l_exp;
         s_sum   <= sum_n;
      end
   end
endmodule

// File: rtl/fpa_seg_norm.sv
// Segment 4: normalization, saturation and flush to zero
module fpa_seg_norm #(
   parameter int unsigned EW = 8,
   parameter int unsigned MW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_valid,
   input  logic          s_sign,
   input  logic [EW-1:0] s_exp,
   input  logic [MW:0]   s_sum,
   output logic          out_valid,
   output logic          out_sign,
   output logic [EW-1:0] out_exp,
   output logic [MW-1:0] out_man
);
   localparam int unsigned LZW = $clog2(MW + 1);
   localparam int unsigned CW  = ((EW > LZW) ? EW : LZW) + 1;

   logic [LZW-1:0] lz;
   logic [CW-1:0]  lz_w;
   logic [CW-1:0]  e_w;
   logic           n_sign;
   logic [EW-1:0]  n_exp;
   logic [MW-1:0]  n_man;

   // Leading-zero count of the lower MW bits; the highest set bit wins
   always_comb begin
      lz = LZW'(MW);
      for (int i = 0; i < MW; i++) begin
         if (s_sum[i]) lz = LZW'(MW - 1 - i);
      end
      lz_w = CW'(lz);
      e_w  = CW'(s_exp);
   end

   always_comb begin
      n_sign = s_sign;
      n_exp  = s_exp;
      n_man  = s_sum[MW-1:0];
      if (s_sum == '0) begin
         n_sign = 1'b0;
         n_exp  = '0;
         n_man  = '0;
      end else if (s_sum[MW]) begin
         if (s_exp == '1) begin
            n_exp = '1;
            n_man = '1;
         end else begin
            n_exp = s_exp + 1'b1;
            n_man = s_sum[MW:1];
         end
      end else if (lz_w > e_w) begin
         n_sign = 1'b0;
         n_exp  = '0;
         n_man  = '0;
      end else begin
         n_exp = EW'(e_w - lz_w);
         n_man = s_sum[MW-1:0] << lz;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sign  <= 1'b0;
         out_exp   <= '0;
         out_man   <= '0;
      end else begin
         out_valid <= s_valid;
         out_sign  <= n_sign;
         out_exp   <= n_exp;
         out_man   <= n_man;
      end
   end
endmodule

// File: rtl/fpa_pipe_adder.sv
// Four-segment pipelined floating-point adder/subtractor
module fpa_pipe_adder #(
   parameter int unsigned EW = fpa_pkg::FPA_EW_DEF,
   parameter int unsigned MW = fpa_pkg::FPA_MW_DEF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sub,
   input  logic          a_sign,
   input  logic [EW-1:0] a_exp,
   input  logic [MW-1:0] a_man,
   input  logic          b_sign,
   input  logic [EW-1:0] b_exp,
   input  logic [MW-1:0] b_man,
   output logic          out_valid,
   output logic          out_sign,
   output logic [EW-1:0] out_exp,
   output logic [MW-1:0] out_man
);
   generate
      if (EW < 2 || EW > 16) begin : g_bad_ew
         $error("fpa_pipe_adder: EW must lie in 2..16");
      end
      if (MW < 2 || MW > 64) begin : g_bad_mw
         $error("fpa_pipe_adder: MW must lie in 2..64");
      end
   endgenerate

   logic          c_valid, c_big_sign, c_sml_sign;
   logic [EW-1:0] c_big_exp, c_diff;
   logic [MW-1:0] c_big_man, c_sml_man;

   logic          l_valid, l_big_sign, l_sml_sign;
   logic [EW-1:0] l_exp;
   logic [MW-1:0] l_big_man, l_sml_man;

   logic          s_valid, s_sign;
   logic [EW-1:0] s_exp;
   logic [MW:0]   s_sum;

   fpa_seg_cmp #(.EW(EW), .MW(MW)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sub(in_sub),
      .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
      .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
      .c_valid(c_valid), .c_big_sign(c_big_sign), .c_big_exp(c_big_exp),
      .c_big_man(c_big_man), .c_sml_sign(c_sml_sign), .c_sml_man(c_sml_man),
      .c_diff(c_diff)
   );

   fpa_seg_align #(.EW(EW), .MW(MW)) u_align (
      .clk(clk), .rst_n(rst_n),
      .c_valid(c_valid), .c_big_sign(c_big_sign), .c_big_exp(c_big_exp),
      .c_big_man(c_big_man), .c_sml_sign(c_sml_sign), .c_sml_man(c_sml_man),
      .c_diff(c_diff),
      .l_valid(l_valid), .l_big_sign(l_big_sign), .l_sml_sign(l_sml_sign),
      .l_exp(l_exp), .l_big_man(l_big_man), .l_sml_man(l_sml_man)
   );

   fpa_seg_addsub #(.EW(EW), .MW(MW)) u_addsub (
      .clk(clk), .rst_n(rst_n),
      .l_valid(l_valid), .l_big_sign(l_big_sign), .l_sml_sign(l_sml_sign),
      .l_exp(l_exp), .l_big_man(l_big_man), .l_sml_man(l_sml_man),
      .s_valid(s_valid), .s_sign(s_sign), .s_exp(s_exp), .s_sum(s_sum)
   );

   fpa_seg_norm #(.EW(EW), .MW(MW)) u_norm (
      .clk(clk), .rst_n(rst_n),
      .s_valid(s_valid), .s_sign(s_sign), .s_exp(s_exp), .s_sum(s_sum),
      .out_valid(out_valid), .out_sign(out_sign),
      .out_exp(out_exp), .out_man(out_man)
   );
endmodule

// File: rtl/fpa_pipe_adder_chk.sv
// Property checker attached to the adder top
module fpa_pipe_adder_chk #(
   parameter int unsigned EW = 8,
   parameter int unsigned MW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [EW-1:0] a_exp,
   input logic [EW-1:0] b_exp,
   input logic          out_valid,
   input logic          out_sign,
   input logic [EW-1:0] out_exp,
   input logic [MW-1:0] out_man
);
   logic [2:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst < 3'd4)  since_rst <= since_rst + 3'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4))); // R1

   AST_EXP_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
      ((since_rst >= 3'd4) && out_valid) |->
      ({1'b0, out_exp} <= ((($past(a_exp, 4) > $past(b_exp, 4)) ?
                             {1'b0, $past(a_exp, 4)} : {1'b0, $past(b_exp, 4)}) + 1'b1))); // R6

   AST_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_man != '0)) |-> out_man[MW-1]); // R8

   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && (out_man == '0)) |-> ((out_exp == '0) && !out_sign)); // R10
endmodule

bind fpa_pipe_adder fpa_pipe_adder_chk #(.EW(EW), .MW(MW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
   .a_exp(a_exp), .b_exp(b_exp),
   .out_valid(out_valid), .out_sign(out_sign),
   .out_exp(out_exp), .out_man(out_man)
);

// File: tb/test_fpa_pipe_adder.sv
module test_fpa_pipe_adder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sub = 1'b0;
   logic        a_sign = 1'b0, b_sign = 1'b0;
   logic [7:0]  a_exp = '0, b_exp = '0;
   logic [15:0] a_man = '0, b_man = '0;
   logic        out_valid, out_sign;
   logic [7:0]  out_exp;
   logic [15:0] out_man;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   string cur_tag = "R1";

   typedef struct {
      int          due;
      logic [24:0] word;
      string       tag;
   } exp_t;
   exp_t q[$];

   always #5 clk = ~clk;

   fpa_pipe_adder i_fpa_pipe_adder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
      .a_sign(a_sign), .a_exp(a_exp), .a_man(a_man),
      .b_sign(b_sign), .b_exp(b_exp), .b_man(b_man),
      .out_valid(out_valid), .out_sign(out_sign),
      .out_exp(out_exp), .out_man(out_man)
   );

   // Behavioural reference built from the requirements
   function automatic logic [24:0] ref_result(bit as, int ae, int am,
                                              bit bs, int be, int bm, bit sub);
      bit bse, bg_s, sm_s, rs;
      int bg_e, bg_m, sm_m, d, al, sum, lz;
      bse = bs ^ sub;
      if (be > ae) begin
         bg_s = bse; bg_e = be; bg_m = bm; sm_s = as; sm_m = am; d = be - ae;
      end else begin
         bg_s = as; bg_e = ae; bg_m = am; sm_s = bse; sm_m = bm; d = ae - be;
      end
      al = (d >= 16) ? 0 : (sm_m >> d);
      if (bg_s == sm_s) begin sum = bg_m + al; rs = bg_s; end
      else if (bg_m >= al) begin sum = bg_m - al; rs = bg_s; end
      else begin sum = al - bg_m; rs = sm_s; end
      if (sum == 0) return 25'd0;
      if (sum >= 65536) begin
         if (bg_e == 255) return {rs, 8'hFF, 16'hFFFF};
         return {rs, 8'(bg_e + 1), 16'(sum >> 1)};
      end
      lz = 0;
      while (sum < 32768) begin sum = sum << 1; lz++; end
      if (lz > bg_e) return 25'd0;
      return {rs, 8'(bg_e - lz), 16'(sum)};
   endfunction

   task automatic chk(bit ok, string req, logic [24:0] act, logic [24:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Output sampling away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         q.delete();
         chk(out_valid == 1'b0, "R11", {24'd0, out_valid}, 25'd0);
      end else begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t it;
            it = q.pop_front();
            chk(out_valid == 1'b1, {it.tag, " valid"}, {24'd0, out_valid}, 25'd1);
            chk({out_sign, out_exp, out_man} == it.word, it.tag,
                {out_sign, out_exp, out_man}, it.word);
         end else begin
            chk(out_valid == 1'b0, "R1 idle", {24'd0, out_valid}, 25'd0);
         end
         if (in_valid) begin
            exp_t n;
            n.due  = cyc + 4;
            n.word = ref_result(a_sign, a_exp, a_man, b_sign, b_exp, b_man, in_sub);
            n.tag  = cur_tag;
            q.push_back(n);
         end
      end
   end

   task automatic drive(string tag, bit as, int ae, int am, bit bs, int be, int bm, bit sub);
      @(posedge clk); #1;
      cur_tag  = tag;
      in_valid = 1'b1; in_sub = sub;
      a_sign = as; a_exp = 8'(ae); a_man = 16'(am);
      b_sign = bs; b_exp = 8'(be); b_man = 16'(bm);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   task automatic rand_pair(string tag);
      int ae, be;
      ae = $urandom_range(0, 255);
      be = ae + $urandom_range(0, 40) - 20;
      if (be < 0) be = 0;
      if (be > 255) be = 255;
      drive(tag, 1'($urandom_range(0, 1)), ae, $urandom_range(0, 65535),
            1'($urandom_range(0, 1)), be, $urandom_range(0, 65535),
            1'($urandom_range(0, 1)));
   endtask

   initial begin : watchdog
      #2000000;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      idle(3);                                   // R11: reset state observed
      @(posedge clk); #1; rst_n = 1'b1;
      idle(2);
      drive("R6",  0, 10, 'h8000, 0, 10, 'h8000, 0);  // carry: e11 m8000
      drive("R7",  0, 255,'h8000, 0, 255,'h8000, 0);  // saturation
      drive("R8",  0, 20, 'h8000, 0, 20, 'h7FFF, 1);  // lz 15: e5 m8000
      drive("R9",  0, 10, 'h8000, 0, 10, 'h7FFF, 1);  // lz 15 > 10: zero
      drive("R10", 1, 40, 'h9234, 1, 40, 'h9234, 1);  // exact cancellation
      drive("R2",  0, 10, 'hC000, 1, 10, 'h4000, 1);  // a - (-b): e11 m8000
      drive("R3",  0, 10, 'h8000, 0, 12, 'h8000, 0);  // d=2: e12 mA000
      drive("R4",  0, 30, 'h8000, 0, 10, 'hFFFF, 0);  // d=20: e30 m8000
      drive("R4",  0, 30, 'h8000, 0, 14, 'hFFFF, 0);  // d=16: e30 m8000
      drive("R3",  0, 30, 'h8000, 0, 15, 'hFFFF, 0);  // d=15: e30 m8001
      drive("R5",  0, 10, 'h4000, 1, 10, 'hC000, 0);  // larger is b: sign 1
      drive("R5",  1, 10, 'hC000, 0, 9,  'h8000, 0);  // e10 m8000 sign 1
      idle(6);
      for (int i = 0; i < 60; i++) rand_pair("R1");   // back-to-back stream
      for (int i = 0; i < 40; i++) begin
         rand_pair("R5");
         if (i % 3 == 0) idle(1);
      end
      drive("R7",  1, 255,'hFFFF, 0, 255,'h0001, 1);  // negative saturation
      drive("R9",  0, 3,  'h0010, 0, 3,  'h0000, 0);  // lz 11 > 3: zero
      drive("R8",  0, 11, 'h0010, 0, 0,  'h0000, 0);  // lz 11: e0 m8000
      for (int i = 0; i < 4; i++) rand_pair("R1");
      @(posedge clk); #1; in_valid = 1'b0; rst_n = 1'b0;  // R11: mid-stream reset
      idle(2);
      @(posedge clk); #1; rst_n = 1'b1;
      idle(8);                                     // no stale results (R11)
      drive("R6",  0, 100,'hFFFF, 0, 100,'hFFFF, 0);  // e101 mFFFF
      idle(8);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule